// File: doc/BRIEF.md
# Programmable Message Time Tag Counter

This block keeps a 16-bit relative time value that a message engine copies into each message record. In normal operation it advances from a free-running microsecond tick through a small prescaler, whose period is picked by a 3-bit resolution code. One code makes the counter follow rising edges of an asynchronous external tag clock instead. Another code freezes the counter.

Two synchronize events from the command decoder can change the count directly. A synchronize event without data can clear it to zero. A synchronize event with data can load it with the received data word. The load can be limited to data words whose least significant bit is zero. A rollover interrupt pulse can be enabled; it marks the wrap from the top value to zero.

Top module: `msg_time_stamp`

## Requirements
- R1: While `rst_n` is low, `count` is 0000h, `roll_irq` is 0 and the prescaler is cleared.
- R2: With `res_sel` = n for n in 0..5, `count` advances by one every 2^(n+1) cycles with `us_tick` high. The step takes effect at the clock edge that samples the last tick of the period. Cycles with `us_tick` low do not count.
- R3: With `res_sel` = 7, each rising edge of `ext_tag_clk` advances `count` by one. The new value appears at the third rising clock edge after the input rises, as long as the input stays at each level for at least three clock cycles. `us_tick` has no effect in this mode.
- R4: With `res_sel` = 6, `count` holds its value. `us_tick` and `ext_tag_clk` are ignored.
- R5: When `clr_en` and `sync_clr_pulse` are both high at a clock edge, `count` becomes 0000h at that edge and the prescaler restarts. When `clr_en` is low, the pulse is ignored.
- R6: When `load_en` and `sync_load_pulse` are both high at a clock edge and the filter allows it, `count` takes the value of `sync_data` at that edge and the prescaler restarts. When `load_en` is low, the pulse is ignored.
- R7: When `load_lsb_filt` is high, a load is carried out only if `sync_data` bit 0 is 0. Otherwise `count` is unaffected.
- R8: Within one cycle, a clear wins over a load, and a load wins over an increment. An increment that is overridden is lost.
- R9: `roll_irq` is high for exactly one cycle, at the edge where an increment wraps `count` from FFFFh to 0000h, and only when `roll_irq_en` is high. A clear or a load never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| res_sel | input | 3 | Resolution code: 0..5 internal, 6 hold, 7 external |
| ext_tag_clk | input | 1 | Asynchronous external tag clock |
| sync_clr_pulse | input | 1 | Synchronize event without data |
| sync_load_pulse | input | 1 | Synchronize event with data |
| sync_data | input | 16 | Received data word for the load |
| clr_en | input | 1 | Enables the clear on synchronize |
| load_en | input | 1 | Enables the load on synchronize with data |
| load_lsb_filt | input | 1 | Allows the load only when data bit 0 is 0 |
| roll_irq_en | input | 1 | Enables the rollover pulse |
| count | output | 16 | Current time tag value |
| roll_irq | output | 1 | Rollover interrupt pulse |

## Verification
The bench drives inputs just after a falling edge and reads the outputs after the next falling edge. Clears, loads and internal increments are therefore seen one clock edge after the stimulus, and that is the only point where they are sampled. External-clock increments pass through two synchronizer flops and an edge register. For those, the bench checks that the count is unchanged after two edges and has advanced after the third. The rollover pulse is read in the same sample as the wrapped count, and again one cycle later to confirm it has dropped.

// File: rtl/msg_time_stamp.sv
module msg_time_stamp #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic [2:0]       res_sel,
  input  logic             ext_tag_clk,
  input  logic             sync_clr_pulse,
  input  logic             sync_load_pulse,
  input  logic [CNT_W-1:0] sync_data,
  input  logic             clr_en,
  input  logic             load_en,
  input  logic             load_lsb_filt,
  input  logic             roll_irq_en,
  output logic [CNT_W-1:0] count,
  output logic             roll_irq
);
  localparam logic [2:0] HOLD_CODE = 3'd6;
  localparam logic [2:0] EXT_CODE  = 3'd7;

  logic [DIV_W-1:0] pre;
  logic [DIV_W:0]   lim;
  logic [2:0]       ext_sync;
  logic             int_mode, pre_wrap, inc, clr_hit, load_hit;

  assign int_mode = (res_sel != HOLD_CODE) && (res_sel != EXT_CODE);
  assign lim      = (DIV_W+1)'(2) << res_sel;
  assign pre_wrap = ({1'b0, pre} + 1'b1) >= lim;
  assign clr_hit  = clr_en && sync_clr_pulse;
  assign load_hit = load_en && sync_load_pulse && !(load_lsb_filt && sync_data[0]);
  assign inc      = int_mode ? (us_tick && pre_wrap)
                  : (res_sel == EXT_CODE) && ext_sync[1] && !ext_sync[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_tag_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  pre <= '0;
    else if (clr_hit || load_hit) pre <= '0;
    else if (int_mode && us_tick) pre <= pre_wrap ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count    <= '0;
      roll_irq <= 1'b0;
    end else begin
      roll_irq <= !clr_hit && !load_hit && inc && roll_irq_en && (&count);
      if (clr_hit)       count <= '0;
      else if (load_hit) count <= sync_data;
      else if (inc)      count <= count + 1'b1;
    end
endmodule

module msg_time_stamp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       res_sel,
  input logic             sync_clr_pulse,
  input logic             sync_load_pulse,
  input logic [CNT_W-1:0] sync_data,
  input logic             clr_en,
  input logic             load_en,
  input logic             load_lsb_filt,
  input logic             roll_irq_en,
  input logic [CNT_W-1:0] count,
  input logic             roll_irq
);
  logic do_clr, do_ld;
  assign do_clr = clr_en && sync_clr_pulse;
  assign do_ld  = load_en && sync_load_pulse && !(load_lsb_filt && sync_data[0]);

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_clr && !do_ld |=> (count == $past(count)) || (count == $past(count) + 1'b1));
  // R4
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel == 3'd6) && !do_clr && !do_ld |=> $stable(count));
  // R5
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> (count == '0) && !roll_irq);
  // R6
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_ld && !do_clr |=> (count == $past(sync_data)) && !roll_irq);
  // R7
  lsb_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel == 3'd6) && !do_clr && load_en && sync_load_pulse && load_lsb_filt && sync_data[0]
    |=> $stable(count));
  // R9
  roll_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_irq |-> (count == '0) && ($past(count) == '1));
  // R9
  roll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roll_irq_en |=> !roll_irq);
  // R9
  roll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_irq |=> !roll_irq);
endmodule

bind msg_time_stamp msg_time_stamp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_sel(res_sel),
  .sync_clr_pulse(sync_clr_pulse), .sync_load_pulse(sync_load_pulse),
  .sync_data(sync_data), .clr_en(clr_en), .load_en(load_en),
  .load_lsb_filt(load_lsb_filt), .roll_irq_en(roll_irq_en),
  .count(count), .roll_irq(roll_irq)
);

// File: tb/tb_msg_time_stamp.sv
module tb_msg_time_stamp;
  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, ext_tag_clk = 1'b0;
  logic [2:0] res_sel = 3'd6;
  logic sync_clr_pulse = 1'b0, sync_load_pulse = 1'b0;
  logic [15:0] sync_data = '0;
  logic clr_en = 1'b0, load_en = 1'b0, load_lsb_filt = 1'b0, roll_irq_en = 1'b0;
  logic [15:0] count;
  logic roll_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msg_time_stamp dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .res_sel(res_sel),
    .ext_tag_clk(ext_tag_clk), .sync_clr_pulse(sync_clr_pulse),
    .sync_load_pulse(sync_load_pulse), .sync_data(sync_data),
    .clr_en(clr_en), .load_en(load_en), .load_lsb_filt(load_lsb_filt),
    .roll_irq_en(roll_irq_en), .count(count), .roll_irq(roll_irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    us_tick = 1'b1; step(); us_tick = 1'b0;
  endtask

  task automatic do_clear();
    clr_en = 1'b1; sync_clr_pulse = 1'b1; step(); sync_clr_pulse = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] d);
    load_en = 1'b1; sync_data = d; sync_load_pulse = 1'b1; step(); sync_load_pulse = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    chk("R1 count in reset", count, 0);
    chk("R1 irq in reset", roll_irq, 0);
    rst_n = 1'b1;
    step();

    // R2: sweep every internal resolution code
    for (int code = 0; code < 6; code++) begin
      int per;
      per = 2 << code;
      res_sel = code[2:0];
      do_clear();
      for (int t = 1; t <= 3*per + 1; t++) begin
        tick1();
        chk("R2 prescaled count", count, t / per);
        if (t % 3 == 0) begin
          step();
          chk("R2 idle cycle", count, t / per);
        end
      end
    end

    // R3: external clock, three-edge latency
    res_sel = 3'd7;
    do_clear();
    for (int i = 1; i <= 4; i++) begin
      ext_tag_clk = 1'b1; us_tick = 1'b1;
      step(); step();
      chk("R3 before sync", count, i - 1);
      step();
      chk("R3 after sync", count, i);
      ext_tag_clk = 1'b0;
      step(); step(); step();
      chk("R3 falling no step", count, i);
      us_tick = 1'b0;
    end

    // R4: hold code ignores ticks and external edges
    res_sel = 3'd6;
    us_tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ext_tag_clk = ~ext_tag_clk;
      step(); step(); step();
    end
    us_tick = 1'b0; ext_tag_clk = 1'b0;
    chk("R4 hold", count, 4);

    // R6 / R7 / R5 in hold mode
    do_load(16'h1234);
    chk("R6 load", count, 16'h1234);
    load_lsb_filt = 1'b1;
    do_load(16'h5679);
    chk("R7 odd word filtered", count, 16'h1234);
    do_load(16'h5678);
    chk("R7 even word loads", count, 16'h5678);
    load_lsb_filt = 1'b0;
    do_load(16'h0001);
    chk("R7 filter off odd loads", count, 16'h0001);
    load_en = 1'b0;
    sync_data = 16'hAAAA; sync_load_pulse = 1'b1; step(); sync_load_pulse = 1'b0;
    chk("R6 load disabled", count, 16'h0001);
    clr_en = 1'b0;
    sync_clr_pulse = 1'b1; step(); sync_clr_pulse = 1'b0;
    chk("R5 clear disabled", count, 16'h0001);
    do_clear();
    chk("R5 clear", count, 0);

    // R6: load restarts the prescaler (code 0, period 2)
    res_sel = 3'd0;
    tick1();
    do_load(16'h0010);
    tick1();
    chk("R6 prescaler restart", count, 16'h0010);
    tick1();
    chk("R6 next step", count, 16'h0011);

    // R8: priorities
    tick1();
    us_tick = 1'b1; clr_en = 1'b1; sync_clr_pulse = 1'b1; step();
    us_tick = 1'b0; sync_clr_pulse = 1'b0;
    chk("R8 clear over increment", count, 0);
    tick1();
    us_tick = 1'b1; load_en = 1'b1; sync_data = 16'h0040; sync_load_pulse = 1'b1; step();
    us_tick = 1'b0; sync_load_pulse = 1'b0;
    chk("R8 load over increment", count, 16'h0040);
    sync_clr_pulse = 1'b1; sync_load_pulse = 1'b1; sync_data = 16'h0777; step();
    sync_clr_pulse = 1'b0; sync_load_pulse = 1'b0;
    chk("R8 clear over load", count, 0);

    // R9: rollover pulse
    roll_irq_en = 1'b1;
    do_load(16'hFFFF);
    tick1();
    chk("R9 no wrap yet", roll_irq, 0);
    tick1();
    chk("R9 wrapped count", count, 0);
    chk("R9 irq on wrap", roll_irq, 1);
    step();
    chk("R9 irq one cycle", roll_irq, 0);
    roll_irq_en = 1'b0;
    do_load(16'hFFFF);
    tick1(); tick1();
    chk("R9 disabled count", count, 0);
    chk("R9 disabled irq", roll_irq, 0);
    roll_irq_en = 1'b1;
    do_load(16'hFFFF);
    do_load(16'h0000);
    chk("R9 load to zero no irq", roll_irq, 0);
    do_load(16'hFFFF);
    do_clear();
    chk("R9 clear no irq", roll_irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule